// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer Pair

The block holds two 8-bit timer channels, an upper one and a lower one. Each channel has an up-counter, two compare registers (A and B), three sticky event flags, and a pin pair. The pin pair has an output that the compare events can drive and an input that can trigger a capture. A small register port gives software read and write access to every channel register. Counting is paced by a prescaled clock-enable input called `tick`.

A two-state mode machine picks how the channels work together. In `MODE_SPLIT` each channel counts, compares, clears and captures on its own. Writing clock-select code 3'b100 into the upper control register fires the **join** transition into `MODE_JOINED`. In that mode the pair becomes one 16-bit counter, with the upper count as bits 15:8 and the lower count as bits 7:0. Writing any other clock-select code to the upper control register fires the **split** transition back to `MODE_SPLIT`. Reset always leaves the machine in `MODE_SPLIT`.

In joined mode the flags are shared out between the channels. The upper channel's flags and pin follow full 16-bit events. The lower channel's flags and pin follow low-byte events only. Only the upper channel's clear selection is used, and any clear resets both bytes together.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset, every register of both channels reads 0, all six flags are 0, both output pins are 0 and the mode is split.
- R2: Register map: addr[3] picks the channel (0 upper, 1 lower). addr[2:0] picks the register: 0 control (clock select [2:0], clear select [4:3]), 1 status (compare-B flag bit 7, compare-A flag bit 6, overflow flag bit 5), 2 count, 3 compare A, 4 compare B, 5 pin config (A action [1:0], B action [3:2], edge select [5:4], capture enable bit 6). rdata follows addr combinationally. The flag outputs are {compare-B, compare-A, overflow}.
- R3: In split mode, a channel's count rises by one on each cycle with tick high, provided its clock select is neither 3'b000 nor 3'b100. Otherwise it holds, except when written or cleared.
- R4: In split mode, the overflow flag sets on a counted wrap from 8'hFF to 8'h00. Compare-A sets when a tick finds count equal to compare A. Compare-B sets when a tick finds count equal to compare B while capture is disabled.
- R5: Clear select 2'b01 loads 0 instead of the increment on a compare-A event. Clear select 2'b10 does the same on a compare-B match or a capture. Codes 2'b00 and 2'b11 never clear.
- R6: Pin actions on an event are 00 no change, 01 drive low, 10 drive high, 11 toggle. When both events occur in the same cycle, the A action is applied first and the B action second.
- R7: In joined mode, the low byte advances on every tick whatever the lower clock select holds. The high byte advances when a tick finds the low byte at 8'hFF.
- R8: In joined mode, the upper overflow flag sets only on a 16'hFFFF to 16'h0000 wrap. The lower overflow flag sets on every 8'hFF to 8'h00 wrap of the low byte.
- R9: In joined mode, the upper compare flags and upper pin respond to 16-bit matches against {upper compare, lower compare}. The lower compare flags and lower pin respond to low-byte matches alone.
- R10: In joined mode, the upper clear select alone decides clearing, and a clear zeroes both bytes at once. The lower clear select has no effect.
- R11: Capture edge select: 00 off, 01 rising, 10 falling, 11 both. The pin passes through two synchronising flops before edge detection. When capture is enabled, a chosen edge copies the count into compare B and sets compare-B.
- R12: In joined mode, capture uses the upper pin, the upper edge select and the upper capture enable. It copies each byte into its own channel's compare B and sets compare-B in both channels.
- R13: A flag clears when 0 is written to its status bit after a status read showed it as 1. Writing 0 without that read leaves it set. A set event in the same cycle as the clearing write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 4 | Channel select and register index |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| pin_hi_in | input | 1 | Upper channel capture input |
| pin_lo_in | input | 1 | Lower channel capture input |
| pin_hi_out | output | 1 | Upper channel compare output |
| pin_lo_out | output | 1 | Lower channel compare output |
| flags_hi | output | 3 | Upper flags {cmp B, cmp A, overflow} |
| flags_lo | output | 3 | Lower flags {cmp B, cmp A, overflow} |

## Verification
The bench sweeps compare values under clear-on-match and predicts the count and toggle parity arithmetically. An off-by-one in the clear would leave the count one step out of phase. A joined run that crosses the low byte's match value in several high-byte pages catches a lower channel that clears itself or looks at all 16 bits. It also catches an upper overflow that fires on low-byte wraps. An edge-select sweep over both pin directions exposes swapped encodings. A flag-clear write that coincides with a set event would, in a design with the wrong priority, lose the event.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic {MODE_SPLIT = 1'b0, MODE_JOINED = 1'b1} mode_e;

    localparam logic [2:0] JOIN_CODE = 3'b100;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_STAT = 3'd1;
    localparam logic [2:0] REG_CNT  = 3'd2;
    localparam logic [2:0] REG_CMPA = 3'd3;
    localparam logic [2:0] REG_CMPB = 3'd4;
    localparam logic [2:0] REG_PCFG = 3'd5;

    localparam logic [1:0] CLR_ON_A = 2'b01;
    localparam logic [1:0] CLR_ON_B = 2'b10;

    localparam logic [1:0] ACT_KEEP = 2'b00;
    localparam logic [1:0] ACT_LOW  = 2'b01;
    localparam logic [1:0] ACT_HIGH = 2'b10;

    function automatic logic pin_apply(input logic cur, input logic [1:0] act);
        case (act)
            ACT_KEEP: return cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return ~cur;
        endcase
    endfunction
endpackage

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
module tmr_edge #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       ev
);
    // sh[SYNC-1] is the synchronised level, sh[SYNC] its previous value
    logic [SYNC:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC-1:0], pin};
    end

    logic rise, fall;
    assign rise = sh[SYNC-1] & ~sh[SYNC];
    assign fall = ~sh[SYNC-1] & sh[SYNC];
    assign ev   = (rise & sel[0]) | (fall & sel[1]);
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          sel,
    input  logic [2:0]    idx,
    input  logic [DW-1:0] wdata,
    input  logic          inc,
    input  logic          clr,
    input  logic          ovf_ev,
    input  logic          cma_ev,
    input  logic          cmb_ev,
    input  logic          pinb_ev,
    input  logic          cap_ld,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cmpa,
    output logic [DW-1:0] cmpb,
    output logic [2:0]    clk_sel,
    output logic [1:0]    clr_sel,
    output logic [1:0]    edge_sel,
    output logic          cap_en,
    output logic [2:0]    flags,
    output logic [DW-1:0] rdata,
    output logic          pin_out
);
    logic [1:0] act_a, act_b;
    logic [2:0] armed;
    logic [2:0] set_v, clr_v;

    logic w_ctrl, w_stat, w_cnt, w_cmpa, w_cmpb, w_pcfg, r_stat;
    assign w_ctrl = wr_en && sel && (idx == REG_CTRL);
    assign w_stat = wr_en && sel && (idx == REG_STAT);
    assign w_cnt  = wr_en && sel && (idx == REG_CNT);
    assign w_cmpa = wr_en && sel && (idx == REG_CMPA);
    assign w_cmpb = wr_en && sel && (idx == REG_CMPB);
    assign w_pcfg = wr_en && sel && (idx == REG_PCFG);
    assign r_stat = rd_en && sel && (idx == REG_STAT);

    assign set_v = {cmb_ev, cma_ev, ovf_ev};
    assign clr_v = w_stat ? (armed & ~wdata[7:5]) : 3'b000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cmpa     <= '0;
            cmpb     <= '0;
            clk_sel  <= '0;
            clr_sel  <= '0;
            act_a    <= '0;
            act_b    <= '0;
            edge_sel <= '0;
            cap_en   <= 1'b0;
            flags    <= '0;
            armed    <= '0;
            pin_out  <= 1'b0;
        end else begin
            if (w_cnt)      cnt <= wdata;
            else if (clr)   cnt <= '0;
            else if (inc)   cnt <= cnt + 1'b1;

            if (w_cmpa) cmpa <= wdata;

            if (w_cmpb)      cmpb <= wdata;
            else if (cap_ld) cmpb <= cnt;

            if (w_ctrl) begin
                clk_sel <= wdata[2:0];
                clr_sel <= wdata[4:3];
            end
            if (w_pcfg) begin
                act_a    <= wdata[1:0];
                act_b    <= wdata[3:2];
                edge_sel <= wdata[5:4];
                cap_en   <= wdata[6];
            end

            flags <= set_v | (flags & ~clr_v);
            if (w_stat)      armed <= 3'b000;
            else if (r_stat) armed <= armed | flags;

            pin_out <= pin_apply(pin_apply(pin_out, cma_ev ? act_a : ACT_KEEP),
                                 pinb_ev ? act_b : ACT_KEEP);
        end
    end

    always_comb begin
        rdata = '0;
        case (idx)
            REG_CTRL: begin
                rdata[2:0] = clk_sel;
                rdata[4:3] = clr_sel;
            end
            REG_STAT: rdata[7:5] = flags;
            REG_CNT:  rdata = cnt;
            REG_CMPA: rdata = cmpa;
            REG_CMPB: rdata = cmpb;
            REG_PCFG: begin
                rdata[1:0] = act_a;
                rdata[3:2] = act_b;
                rdata[5:4] = edge_sel;
                rdata[6]   = cap_en;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_pair_top.sv
`timescale 1ns/1ps
module tmr_pair_top
    import tmr_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [3:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          pin_hi_in,
    input  logic          pin_lo_in,
    output logic          pin_hi_out,
    output logic          pin_lo_out,
    output logic [2:0]    flags_hi,
    output logic [2:0]    flags_lo
);
    localparam int NCH   = 2;
    localparam int CH_HI = 0;
    localparam int CH_LO = 1;

    logic [NCH-1:0][DW-1:0] cnt_q, cmpa_q, cmpb_q, rd_ch;
    logic [NCH-1:0][2:0]    clk_sel, flag_q;
    logic [NCH-1:0][1:0]    clr_sel, edge_sel;
    logic [NCH-1:0]         cap_en, edge_ev, pin_in, pin_out;
    logic [NCH-1:0]         inc, clr, ovf_ev, cma_ev, cmb_ev, pinb_ev, cap_ev;
    logic [2*DW-1:0]        cnt16, cmpa16, cmpb16;

    mode_e mode_q, mode_d;
    logic  joined;

    assign pin_in = {pin_lo_in, pin_hi_in};
    assign cnt16  = {cnt_q[CH_HI],  cnt_q[CH_LO]};
    assign cmpa16 = {cmpa_q[CH_HI], cmpa_q[CH_LO]};
    assign cmpb16 = {cmpb_q[CH_HI], cmpb_q[CH_LO]};
    assign joined = (mode_q == MODE_JOINED);

    // mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_SPLIT;
        else        mode_q <= mode_d;
    end

    // join / split transitions on a write to the upper control register
    always_comb begin
        mode_d = mode_q;
        if (wr_en && addr == {1'b0, REG_CTRL}) begin
            unique case (mode_q)
                MODE_SPLIT:  if (wdata[2:0] == JOIN_CODE) mode_d = MODE_JOINED;
                MODE_JOINED: if (wdata[2:0] != JOIN_CODE) mode_d = MODE_SPLIT;
            endcase
        end
    end

    // per-mode event decoding
    always_comb begin
        inc = '0; clr = '0; ovf_ev = '0; cma_ev = '0;
        cmb_ev = '0; pinb_ev = '0; cap_ev = '0;
        unique case (mode_q)
            MODE_SPLIT: begin
                for (int c = 0; c < NCH; c++) begin
                    inc[c]     = tick && (clk_sel[c] != 3'b000) && (clk_sel[c] != JOIN_CODE);
                    cma_ev[c]  = inc[c] && (cnt_q[c] == cmpa_q[c]);
                    pinb_ev[c] = inc[c] && !cap_en[c] && (cnt_q[c] == cmpb_q[c]);
                    cap_ev[c]  = cap_en[c] && edge_ev[c];
                    cmb_ev[c]  = pinb_ev[c] || cap_ev[c];
                    ovf_ev[c]  = inc[c] && (cnt_q[c] == {DW{1'b1}});
                    clr[c]     = ((clr_sel[c] == CLR_ON_A) && cma_ev[c]) ||
                                 ((clr_sel[c] == CLR_ON_B) && cmb_ev[c]);
                end
            end
            MODE_JOINED: begin
                inc[CH_LO]     = tick;
                inc[CH_HI]     = tick && (cnt_q[CH_LO] == {DW{1'b1}});
                cma_ev[CH_HI]  = tick && (cnt16 == cmpa16);
                cma_ev[CH_LO]  = tick && (cnt_q[CH_LO] == cmpa_q[CH_LO]);
                pinb_ev[CH_HI] = tick && !cap_en[CH_HI] && (cnt16 == cmpb16);
                pinb_ev[CH_LO] = tick && !cap_en[CH_HI] && (cnt_q[CH_LO] == cmpb_q[CH_LO]);
                cap_ev         = {NCH{cap_en[CH_HI] && edge_ev[CH_HI]}};
                cmb_ev         = pinb_ev | cap_ev;
                ovf_ev[CH_HI]  = tick && (cnt16 == {(2*DW){1'b1}});
                ovf_ev[CH_LO]  = tick && (cnt_q[CH_LO] == {DW{1'b1}});
                clr            = {NCH{((clr_sel[CH_HI] == CLR_ON_A) && cma_ev[CH_HI]) ||
                                      ((clr_sel[CH_HI] == CLR_ON_B) && cmb_ev[CH_HI])}};
            end
        endcase
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            tmr_edge #(.SYNC(SYNC)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (pin_in[c]),
                .sel   (edge_sel[c]),
                .ev    (edge_ev[c])
            );
            tmr_chan #(.DW(DW)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .rd_en    (rd_en),
                .sel      (int'(addr[3]) == c),
                .idx      (addr[2:0]),
                .wdata    (wdata),
                .inc      (inc[c]),
                .clr      (clr[c]),
                .ovf_ev   (ovf_ev[c]),
                .cma_ev   (cma_ev[c]),
                .cmb_ev   (cmb_ev[c]),
                .pinb_ev  (pinb_ev[c]),
                .cap_ld   (cap_ev[c]),
                .cnt      (cnt_q[c]),
                .cmpa     (cmpa_q[c]),
                .cmpb     (cmpb_q[c]),
                .clk_sel  (clk_sel[c]),
                .clr_sel  (clr_sel[c]),
                .edge_sel (edge_sel[c]),
                .cap_en   (cap_en[c]),
                .flags    (flag_q[c]),
                .rdata    (rd_ch[c]),
                .pin_out  (pin_out[c])
            );
        end
    endgenerate

    assign rdata      = rd_ch[addr[3]];
    assign flags_hi   = flag_q[CH_HI];
    assign flags_lo   = flag_q[CH_LO];
    assign pin_hi_out = pin_out[CH_HI];
    assign pin_lo_out = pin_out[CH_LO];
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          wr_en,
    input logic          joined,
    input logic [DW-1:0] cnt_hi,
    input logic [DW-1:0] cnt_lo,
    input logic [2:0]    flags_hi,
    input logic [2:0]    flags_lo,
    input logic          cap_hi
);
    // R8
    joined_hi_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && $past(joined) && $rose(flags_hi[0]))
        |-> ($past(tick) && $past(cnt_hi) == {DW{1'b1}} && $past(cnt_lo) == {DW{1'b1}}));

    // R8
    joined_lo_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && $past(joined) && $past(tick) && $past(cnt_lo) == {DW{1'b1}})
        |-> flags_lo[0]);

    // R10
    lo_no_solo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && $past(joined) && !$past(wr_en) && $past(cnt_lo) != '0 &&
         $past(cnt_lo) != {DW{1'b1}} && cnt_lo == '0)
        |-> (cnt_hi == '0));

    // R13
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|($past(flags_hi) & ~flags_hi)) || (|($past(flags_lo) & ~flags_lo)))
        |-> $past(wr_en));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(wr_en) && !$past(cap_hi))
        |-> (cnt_hi == $past(cnt_hi)));
endmodule

bind tmr_pair_top tmr_pair_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .joined   (joined),
    .cnt_hi   (cnt_q[0]),
    .cnt_lo   (cnt_q[1]),
    .flags_hi (flags_hi),
    .flags_lo (flags_lo),
    .cap_hi   (cap_ev[0])
);

// File: tb/tmr_pair_top_test.sv
`timescale 1ns/1ps
module tmr_pair_top_test;
    localparam logic [3:0] H_CTRL = 4'h0, H_STAT = 4'h1, H_CNT = 4'h2,
                           H_CMPA = 4'h3, H_CMPB = 4'h4, H_PCFG = 4'h5;
    localparam logic [3:0] L_CTRL = 4'h8, L_STAT = 4'h9, L_CNT = 4'hA,
                           L_CMPA = 4'hB, L_CMPB = 4'hC, L_PCFG = 4'hD;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic       pin_hi_in = 1'b0, pin_lo_in = 1'b0, pin_hi_out, pin_lo_out;
    logic [2:0] flags_hi, flags_lo;

    tmr_pair_top uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pin_hi_in(pin_hi_in), .pin_lo_in(pin_lo_in),
        .pin_hi_out(pin_hi_out), .pin_lo_out(pin_lo_out),
        .flags_hi(flags_hi), .flags_lo(flags_lo)
    );

    int n_run = 0, n_fail = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk); tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d, d2;
        logic pin_exp;
        do_reset();

        // R1 / R2: reset state through the register port
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            chk("R1 reset register", {8'h0, d}, 16'h0);
        end
        chk("R1 reset flags/pins", {8'h0, flags_hi, flags_lo, pin_hi_out, pin_lo_out}, 16'h0);

        // R3 / R6: split counting and pin drive
        wr(H_CTRL, 8'h01); wr(H_CMPA, 8'h01); wr(H_CMPB, 8'h03); wr(H_PCFG, 8'h06);
        wr(L_CTRL, 8'h04);
        ticks(2);
        chk("R6 drive high on A", {15'h0, pin_hi_out}, 16'h1);
        ticks(2);
        chk("R6 drive low on B", {15'h0, pin_hi_out}, 16'h0);
        rd(H_CNT, d);
        chk("R3 upper count", {8'h0, d}, 16'h4);
        rd(L_CNT, d);
        chk("R3 lower with 100 in split holds", {8'h0, d}, 16'h0);
        chk("R4 compare flags set", {13'h0, flags_hi}, 16'h6);

        // R4 overflow + R13 flag clearing
        do_reset();
        wr(H_CTRL, 8'h01); wr(H_CNT, 8'hFA);
        ticks(5);
        chk("R4 no ovf at FF", {15'h0, flags_hi[0]}, 16'h0);
        ticks(1);
        chk("R4 ovf on wrap", {15'h0, flags_hi[0]}, 16'h1);
        wr(H_STAT, 8'h00);
        chk("R13 write without read keeps flag", {15'h0, flags_hi[0]}, 16'h1);
        rd(H_STAT, d);
        chk("R2 status ovf bit5", {15'h0, d[5]}, 16'h1);
        wr(H_STAT, 8'h00);
        chk("R13 read then write 0 clears", {15'h0, flags_hi[0]}, 16'h0);
        wr(H_CMPA, 8'h05); wr(H_CNT, 8'h05);
        ticks(1);
        rd(H_STAT, d);
        wr(H_CNT, 8'h05);
        @(negedge clk); wr_en = 1'b1; addr = H_STAT; wdata = 8'h00; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        chk("R13 set beats clear", {15'h0, flags_hi[1]}, 16'h1);

        // R5 / R6: clear on A sweep with toggle
        do_reset();
        wr(H_CTRL, 8'h09); wr(H_PCFG, 8'h03);
        pin_exp = 1'b0;
        foreach (d2[i]) begin end
        for (int j = 0; j < 5; j++) begin
            int k, n;
            k = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 2 : (j == 3) ? 5 : 9;
            n = 3 * k + 7;
            wr(H_CNT, 8'h00); wr(H_CMPA, 8'(k));
            ticks(n);
            rd(H_CNT, d);
            chk("R5 clear on A count", {8'h0, d}, 16'(n % (k + 1)));
            pin_exp = pin_exp ^ 1'(n / (k + 1));
            chk("R6 toggle parity", {15'h0, pin_hi_out}, {15'h0, pin_exp});
        end

        // R7 / R8: joined counting and overflow
        do_reset();
        wr(H_CTRL, 8'h04); wr(L_CTRL, 8'h00);
        wr(H_CNT, 8'h12); wr(L_CNT, 8'hFD);
        ticks(5);
        rd(H_CNT, d); rd(L_CNT, d2);
        chk("R7 joined count", {d, d2}, 16'h1302);
        chk("R8 lower ovf on byte wrap", {15'h0, flags_lo[0]}, 16'h1);
        chk("R8 upper no ovf on byte wrap", {15'h0, flags_hi[0]}, 16'h0);
        wr(H_CNT, 8'hFF); wr(L_CNT, 8'hFE);
        ticks(1);
        chk("R8 upper no ovf at FFFF", {15'h0, flags_hi[0]}, 16'h0);
        ticks(1);
        chk("R8 upper ovf on 16-bit wrap", {15'h0, flags_hi[0]}, 16'h1);
        rd(H_CNT, d); rd(L_CNT, d2);
        chk("R7 wrap to zero", {d, d2}, 16'h0000);
        wr(H_CTRL, 8'h00);
        ticks(3);
        rd(L_CNT, d);
        chk("R7 split again stops lower", {8'h0, d}, 16'h0);

        // R9 / R10: joined compare and clear
        do_reset();
        wr(H_CMPA, 8'h01); wr(L_CMPA, 8'h04);
        wr(L_CTRL, 8'h09); wr(H_CTRL, 8'h0C);
        wr(H_PCFG, 8'h03); wr(L_PCFG, 8'h03);
        ticks(5);
        rd(H_CNT, d); rd(L_CNT, d2);
        chk("R10 lower clear select ignored", {d, d2}, 16'h0005);
        chk("R9 lower byte match flag", {15'h0, flags_lo[1]}, 16'h1);
        chk("R9 upper no 16-bit match yet", {15'h0, flags_hi[1]}, 16'h0);
        ticks(293);
        begin
            int lo_t;
            lo_t = 0;
            for (int t = 0; t < 298; t++) if (((t % 261) & 255) == 4) lo_t++;
            rd(H_CNT, d); rd(L_CNT, d2);
            chk("R10 16-bit clear period", {d, d2}, 16'(298 % 261));
            chk("R9 upper pin 16-bit toggles", {15'h0, pin_hi_out}, 16'((298 / 261) & 1));
            chk("R9 lower pin byte toggles", {15'h0, pin_lo_out}, 16'(lo_t & 1));
            chk("R9 upper 16-bit match flag", {15'h0, flags_hi[1]}, 16'h1);
        end

        // R12: joined capture
        do_reset();
        wr(H_CTRL, 8'h14); wr(H_PCFG, 8'h50);
        wr(H_CNT, 8'h34); wr(L_CNT, 8'h56);
        pin_hi_in = 1'b1;
        waitc(6);
        rd(H_CMPB, d); rd(L_CMPB, d2);
        chk("R12 capture both bytes", {d, d2}, 16'h3456);
        chk("R12 cmp B flag both channels", {14'h0, flags_hi[2], flags_lo[2]}, 16'h3);
        rd(H_CNT, d); rd(L_CNT, d2);
        chk("R5 capture clears both bytes", {d, d2}, 16'h0000);
        wr(H_CNT, 8'h11); wr(L_CNT, 8'h22);
        pin_hi_in = 1'b0;
        waitc(6);
        rd(H_CMPB, d); rd(L_CMPB, d2);
        chk("R11 falling ignored for rising select", {d, d2}, 16'h3456);

        // R11: split edge-select sweep on lower channel
        do_reset();
        for (int es = 0; es < 4; es++) begin
            wr(L_PCFG, 8'h40 | 8'(es << 4));
            for (int dir = 0; dir < 2; dir++) begin
                int id;
                logic take;
                id = es * 2 + dir + 1;
                wr(L_CMPB, 8'hEE); wr(L_CNT, 8'(id));
                pin_lo_in = (dir == 0);
                waitc(6);
                rd(L_CMPB, d);
                take = (dir == 0) ? es[0] : es[1];
                chk("R11 edge select capture", {8'h0, d}, take ? 16'(id) : 16'h00EE);
            end
        end
        rd(H_CMPB, d);
        chk("R11 upper untouched by lower pin", {8'h0, d}, 16'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule